// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block decides, for every core of a multi-core processor, which of four operating conditions the core is in: running, halted, deep-halted (halted with a lowered bus-to-core ratio), or stop-granted. Each core has its own halt request, wake event and lowest-ratio flag, and a shared enable selects whether a halt may take the deep form. The outputs are three clock-enable bits per core, a ratio-lowering indication per core, and a ratio-restore request that the clock logic must acknowledge before a deep-halted core is given its execution clock back.

A single active-low stop-clock pin, shared by all cores, is brought through a synchronizer and then forces every core into the stop-granted condition. The core remembers where it came from and goes back there when the pin is released. Each entry into stop-grant queues one special-bus-cycle request for that core. A sequencer presents these requests one at a time, lowest-numbered core first, each held until the bus side acknowledges it.

Per-core clock-enable bits: bit 0 is the execution clock, bit 1 the snoop/cache clock, bit 2 the interrupt and bus-interface clock. Core n uses bits [3n+2:3n] of `clk_en_o`.

Top module: `lps_ctrl`

## Requirements
- R1: After reset every core runs with all enable bits at 1. `sg_req_o`, `ratio_low_o` and `restore_req_o` are all 0.
- R2: A halt request while running, with the deep-halt enable at 0, moves the core to halt at the next clock edge. Its enables become 3'b110.
- R3: A halt request while running, with the deep-halt enable at 1 and the core's lowest-ratio flag at 0, moves the core to deep halt at the next edge. Its enables become 3'b100 and `ratio_low_o` goes to 1.
- R4: A halt request while running, with the deep-halt enable at 1 and the core's lowest-ratio flag at 1, enters plain halt (enables 3'b110, `ratio_low_o` 0).
- R5: A wake event in halt returns the core to run (enables 3'b111) at the next edge.
- R6: A wake event in deep halt drops `ratio_low_o` and raises `restore_req_o` at the next edge, with the enables held at 3'b100. The request is held until `restore_ack_i`. The edge that samples the acknowledge returns the core to run (3'b111).
- R7: A low level on `stpclk_ni` passes through a two-stage synchronizer. It places the core in stop-grant (enables 3'b010) at the third rising edge after it is applied, not earlier.
- R8: While a core is in stop-grant, its halt request and wake event have no effect: its enables stay 3'b010.
- R9: Releasing `stpclk_ni` returns the core, three edges later, to the state it held before stop-grant (run, halt or deep halt). A deep-halted core keeps `ratio_low_o` at 1 through stop-grant.
- R10: Each entry of a core into stop-grant produces exactly one bus-cycle request. Requests are presented one at a time on `sg_req_o`/`sg_core_o`, the lowest-numbered core first, and each is held stable until `sg_ack_i`.
- R11: When the synchronized stop-clock and a halt request reach a running core on the same edge, stop-grant wins. The halt request is dropped, so the core comes back to run.
- R12: A core waiting for the ratio-restore acknowledge is not taken into stop-grant. It completes the handshake, runs for one cycle, and then enters stop-grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | NCORES | Per-core halt instruction request (one-cycle pulse) |
| wake_i | input | NCORES | Per-core interrupt / wake event |
| stpclk_ni | input | 1 | Active-low stop-clock pin, asynchronous |
| xhalt_en_i | input | 1 | Deep-halt enable |
| min_ratio_i | input | NCORES | Core already at its lowest bus-to-core ratio |
| restore_ack_i | input | NCORES | Ratio restore completed |
| clk_en_o | output | 3*NCORES | Per-core section clock enables |
| ratio_low_o | output | NCORES | Request to hold the core at its low ratio |
| restore_req_o | output | NCORES | Request to restore the nominal ratio |
| sg_req_o | output | 1 | Stop-grant bus-cycle request |
| sg_core_o | output | IDW | Core index for the pending bus-cycle request |
| sg_ack_i | input | 1 | Bus-cycle request accepted |

## Verification
Two kinds of event can collide on one edge. The first is the synchronized stop-clock arriving together with a halt request. The bench times the halt pulse onto the exact edge where the synchronized level first appears, then checks that the core stop-grants and later comes back to run rather than halt. The second is the stop-clock arriving while a core waits for its ratio-restore acknowledge. There the bench checks that the restore request is held, that the core goes through run for one cycle, and that its bus-cycle request is queued behind the other core's in the scoreboard.

// File: rtl/lps_pkg.sv
package lps_pkg;

    localparam int NSEC = 3;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_HALT,
        ST_DEEP,
        ST_RESTORE,
        ST_STOPG
    } lps_state_e;

    localparam logic [NSEC-1:0] EN_RUN   = 3'b111;
    localparam logic [NSEC-1:0] EN_HALT  = 3'b110;
    localparam logic [NSEC-1:0] EN_DEEP  = 3'b100;
    localparam logic [NSEC-1:0] EN_STOPG = 3'b010;

    typedef struct packed {
        lps_state_e st;
        lps_state_e ret;
    } core_reg_t;

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int STAGES = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RESET_VAL}};
        else         sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lps_core.sv
module lps_core
    import lps_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            stop_i,
    input  logic            halt_req_i,
    input  logic            wake_i,
    input  logic            xhalt_en_i,
    input  logic            min_ratio_i,
    input  logic            restore_ack_i,
    output logic [NSEC-1:0] clk_en_o,
    output logic            ratio_low_o,
    output logic            restore_req_o,
    output logic            enter_sg_o
);
    core_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                if (stop_i) begin
                    r_d.st  = ST_STOPG;
                    r_d.ret = ST_RUN;
                end else if (halt_req_i) begin
                    r_d.st = (xhalt_en_i && !min_ratio_i) ? ST_DEEP : ST_HALT;
                end
            end
            ST_HALT: begin
                if (stop_i) begin
                    r_d.st  = ST_STOPG;
                    r_d.ret = ST_HALT;
                end else if (wake_i) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_DEEP: begin
                if (stop_i) begin
                    r_d.st  = ST_STOPG;
                    r_d.ret = ST_DEEP;
                end else if (wake_i) begin
                    r_d.st = ST_RESTORE;
                end
            end
            ST_RESTORE: begin
                if (restore_ack_i) r_d.st = ST_RUN;
            end
            ST_STOPG: begin
                if (!stop_i) r_d.st = r_q.ret;
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{st: ST_RUN, ret: ST_RUN};
        else         r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            ST_HALT:    clk_en_o = EN_HALT;
            ST_DEEP:    clk_en_o = EN_DEEP;
            ST_RESTORE: clk_en_o = EN_DEEP;
            ST_STOPG:   clk_en_o = EN_STOPG;
            default:    clk_en_o = EN_RUN;
        endcase
    end

    assign ratio_low_o   = (r_q.st == ST_DEEP) ||
                           (r_q.st == ST_STOPG && r_q.ret == ST_DEEP);
    assign restore_req_o = (r_q.st == ST_RESTORE);
    assign enter_sg_o    = (r_d.st == ST_STOPG) && (r_q.st != ST_STOPG);
endmodule

// File: rtl/lps_sg_seq.sv
module lps_sg_seq #(
    parameter int NCORES = 2,
    localparam int IDW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCORES-1:0] enter_i,
    output logic              req_o,
    output logic [IDW-1:0]    core_o,
    input  logic              ack_i
);
    logic [NCORES-1:0] pend_d, pend_q;
    logic [IDW-1:0]    sel;

    always_comb begin
        sel = '0;
        for (int i = NCORES - 1; i >= 0; i--) begin
            if (pend_q[i]) sel = IDW'(i);
        end
    end

    always_comb begin
        pend_d = pend_q;
        if (req_o && ack_i) pend_d[sel] = 1'b0;
        pend_d = pend_d | enter_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign req_o  = |pend_q;
    assign core_o = sel;
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int NCORES      = 2,
    parameter int SYNC_STAGES = 2,
    localparam int IDW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NCORES-1:0]      halt_req_i,
    input  logic [NCORES-1:0]      wake_i,
    input  logic                   stpclk_ni,
    input  logic                   xhalt_en_i,
    input  logic [NCORES-1:0]      min_ratio_i,
    input  logic [NCORES-1:0]      restore_ack_i,
    output logic [NSEC*NCORES-1:0] clk_en_o,
    output logic [NCORES-1:0]      ratio_low_o,
    output logic [NCORES-1:0]      restore_req_o,
    output logic                   sg_req_o,
    output logic [IDW-1:0]         sg_core_o,
    input  logic                   sg_ack_i
);
    logic              stpclk_n_s;
    logic              stop;
    logic [NCORES-1:0] enter_sg;

    lps_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (stpclk_ni),
        .q_o    (stpclk_n_s)
    );

    assign stop = !stpclk_n_s;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        lps_core i_core (
            .clk_i         (clk_i),
            .rst_ni        (rst_ni),
            .stop_i        (stop),
            .halt_req_i    (halt_req_i[c]),
            .wake_i        (wake_i[c]),
            .xhalt_en_i    (xhalt_en_i),
            .min_ratio_i   (min_ratio_i[c]),
            .restore_ack_i (restore_ack_i[c]),
            .clk_en_o      (clk_en_o[c*NSEC +: NSEC]),
            .ratio_low_o   (ratio_low_o[c]),
            .restore_req_o (restore_req_o[c]),
            .enter_sg_o    (enter_sg[c])
        );
    end

    lps_sg_seq #(.NCORES(NCORES)) i_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .enter_i (enter_sg),
        .req_o   (sg_req_o),
        .core_o  (sg_core_o),
        .ack_i   (sg_ack_i)
    );
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk #(
    parameter int NCORES = 2,
    parameter int IDW    = 1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [3*NCORES-1:0] clk_en_o,
    input logic [NCORES-1:0]   ratio_low_o,
    input logic [NCORES-1:0]   restore_req_o,
    input logic [NCORES-1:0]   restore_ack_i,
    input logic                sg_req_o,
    input logic [IDW-1:0]      sg_core_o,
    input logic                sg_ack_i
);
    assert_sg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sg_req_o && !sg_ack_i) |=> (sg_req_o && $stable(sg_core_o)));

    assert_sg_drop_acked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sg_req_o) |-> $past(sg_ack_i));

    for (genvar c = 0; c < NCORES; c++) begin : g_chk
        assert_restore_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (restore_req_o[c] && !restore_ack_i[c]) |=> restore_req_o[c]);

        assert_restore_exec_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            restore_req_o[c] |-> (clk_en_o[3*c +: 3] == 3'b100));

        assert_low_vs_restore_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0({ratio_low_o[c], restore_req_o[c]}));

        assert_exec_implies_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clk_en_o[3*c] |-> (clk_en_o[3*c +: 3] == 3'b111));
    end
endmodule

bind lps_ctrl lps_ctrl_chk #(.NCORES(NCORES), .IDW(IDW)) i_lps_ctrl_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clk_en_o      (clk_en_o),
    .ratio_low_o   (ratio_low_o),
    .restore_req_o (restore_req_o),
    .restore_ack_i (restore_ack_i),
    .sg_req_o      (sg_req_o),
    .sg_core_o     (sg_core_o),
    .sg_ack_i      (sg_ack_i)
);

// File: tb/test_lps_ctrl.sv
`timescale 1ns/1ps
module test_lps_ctrl;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] halt_req = '0, wake = '0, min_ratio = '0, restore_ack = '0;
    logic          stpclk_n = 1'b1, xhalt_en = 1'b0, sg_ack = 1'b0;
    logic [3*NC-1:0] clk_en;
    logic [NC-1:0] ratio_low, restore_req;
    logic          sg_req;
    logic [0:0]    sg_core;

    int total = 0, bad = 0, sg_seen = 0;
    int exp_q[$];
    bit done = 0;

    always #5 clk = ~clk;

    lps_ctrl #(.NCORES(NC)) i_lps_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt_req), .wake_i(wake),
        .stpclk_ni(stpclk_n), .xhalt_en_i(xhalt_en), .min_ratio_i(min_ratio),
        .restore_ack_i(restore_ack), .clk_en_o(clk_en), .ratio_low_o(ratio_low),
        .restore_req_o(restore_req), .sg_req_o(sg_req), .sg_core_o(sg_core),
        .sg_ack_i(sg_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_halt(input logic [NC-1:0] m);
        halt_req = m; @(negedge clk); halt_req = '0;
    endtask

    task automatic pulse_wake(input logic [NC-1:0] m);
        wake = m; @(negedge clk); wake = '0;
    endtask

    // scoreboard monitor: compares each bus-cycle request against the queue
    initial begin
        forever begin
            @(negedge clk);
            sg_ack = 1'b0;
            if (sg_req) begin
                sg_seen++;
                if (exp_q.size() == 0) chk("R10 unexpected request", {31'd0, sg_core}, 32'hffff_ffff);
                else chk("R10 order", {31'd0, sg_core}, exp_q.pop_front());
                sg_ack = 1'b1;
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 enables", clk_en, 6'b111111);
        chk("R1 sg_req", sg_req, 0);
        chk("R1 ratio_low", ratio_low, 0);
        chk("R1 restore_req", restore_req, 0);

        pulse_halt(2'b01);
        chk("R2 halt core0", clk_en, 6'b111110);
        pulse_wake(2'b01);
        chk("R5 wake core0", clk_en, 6'b111111);

        xhalt_en = 1'b1; min_ratio = 2'b01;
        pulse_halt(2'b10);
        chk("R3 deep core1", clk_en, 6'b100111);
        chk("R3 ratio_low", ratio_low, 2'b10);
        pulse_halt(2'b01);
        chk("R4 fallback core0", clk_en, 6'b100110);
        chk("R4 ratio_low", ratio_low, 2'b10);

        exp_q.push_back(0); exp_q.push_back(1);
        stpclk_n = 1'b0;
        cyc(2);
        chk("R7 not yet", clk_en, 6'b100110);
        cyc(1);
        chk("R7 stop grant", clk_en, 6'b010010);
        chk("R9 ratio kept", ratio_low, 2'b10);
        halt_req = 2'b11; wake = 2'b11;
        cyc(1);
        halt_req = '0; wake = '0;
        cyc(1);
        chk("R8 ignored", clk_en, 6'b010010);
        stpclk_n = 1'b1;
        cyc(3);
        chk("R9 return", clk_en, 6'b100110);
        chk("R9 ratio_low", ratio_low, 2'b10);

        pulse_wake(2'b10);
        chk("R6 restore req", restore_req, 2'b10);
        chk("R6 ratio dropped", ratio_low, 2'b00);
        cyc(2);
        chk("R6 held", clk_en, 6'b100110);
        restore_ack = 2'b10; @(negedge clk); restore_ack = '0;
        chk("R6 run", clk_en, 6'b111110);
        chk("R6 req cleared", restore_req, 0);
        pulse_wake(2'b01);
        chk("R5 wake core0 again", clk_en, 6'b111111);

        exp_q.push_back(0); exp_q.push_back(1);
        stpclk_n = 1'b0;
        cyc(2);
        pulse_halt(2'b11);
        chk("R11 stop wins", clk_en, 6'b010010);
        stpclk_n = 1'b1;
        cyc(3);
        chk("R11 back to run", clk_en, 6'b111111);

        min_ratio = 2'b00;
        pulse_halt(2'b10);
        pulse_wake(2'b10);
        chk("R12 restoring", restore_req, 2'b10);
        exp_q.push_back(0);
        stpclk_n = 1'b0;
        cyc(4);
        chk("R12 deferred", clk_en, 6'b100010);
        chk("R12 req held", restore_req, 2'b10);
        exp_q.push_back(1);
        restore_ack = 2'b10; @(negedge clk); restore_ack = '0;
        chk("R12 run cycle", clk_en, 6'b111010);
        cyc(1);
        chk("R12 stop grant", clk_en, 6'b010010);
        stpclk_n = 1'b1;
        cyc(6);
        chk("R12 return", clk_en, 6'b111111);

        chk("R10 queue drained", exp_q.size(), 0);
        chk("R10 request count", sg_seen, 6);
        chk("R10 idle", sg_req, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule